// File: doc/BRIEF.md
# Nibble-bus serial byte transmitter

This block attaches a byte-wide serial transmitter to a 4-bit processor bus. Software assembles a byte in a transmit holding register using two nibble writes. The block then moves the byte into a shift register on its own and sends it out most significant bit first. After the eight data slots it leaves one slot for the far end's acknowledge. It keeps the acknowledge level from the last telegram, shows whether the holding register is occupied and whether a telegram is on the line, and raises an interrupt that can be masked. The interrupt fires either when the holding register is emptied or when a telegram completes.

Two bus locations are used. Location 0xA holds four control bits on writes and returns status on reads. Location 0x9 is the holding register. The bus never stalls: every write is taken on the clock edge where `bus_we_i` is high, and reads are combinational from `bus_addr_i`. The serial side has no back-pressure either. Each slot lasts `SLOT_CYCLES` clocks, and `ser_clk_en_o` marks the last clock of every slot, where the receiver samples.

Top module: `nib_ser_tx`

## Requirements
- R1: After reset, `ctrl_link_off_o` and `ctrl_rack_o` are 1, `irq_o` is 0, `ser_data_o` is 1, and a read of 0xA returns 4'b0100 (acknowledge status 1, not active, holding register empty).
- R2: A write to 0xA stores the data on the following edge. Bit 3 drives `ctrl_link_off_o`, bit 2 drives `ctrl_rack_o`, bit 1 is the interrupt mask (1 = blocked) and bit 0 is the trigger select (1 = end of telegram, 0 = holding register emptied).
- R3: A read of 0xA returns bit 3 = 0, bit 2 = acknowledge status, bit 1 = telegram active and bit 0 = holding register full. A read of any other address returns 0.
- R4: Writes to 0x9 alternate between halves, starting after reset with the low half. The first write of a pair fills bits 3..0 and the second fills bits 7..4. The full flag rises on the edge of the second write and no earlier.
- R5: When the shifter is idle and the holding register is full, the byte is taken on the next edge. From the following cycle the full flag reads 0 and the active flag reads 1.
- R6: A telegram is nine slots of `SLOT_CYCLES` clocks each. During slots 0..7, `ser_data_o` carries byte bit 7 down to bit 0. In slot 8 and whenever idle, `ser_data_o` is 1. `ser_clk_en_o` is 1 only on the last clock of each slot of an active telegram.
- R7: `ser_ack_i` is sampled on the last clock of slot 8. The acknowledge status then equals that level (0 = acknowledge received, 1 = none), and the active flag clears on the same edge.
- R8: With the mask at 0, `irq_o` is a one-cycle pulse. With trigger select 0 it appears two cycles after the take cycle. With trigger select 1 it appears two cycles after the last clock of slot 8. With the mask at 1, `irq_o` stays 0.
- R9: A byte completed while a telegram is being sent stays held with the full flag at 1. It is taken on the edge after the cycle in which the active flag first reads 0.
- R10: Further writes to 0x9 while the register is full overwrite the half selected by the pointer. The byte sent is the last low half with the last high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 4 | Bus address |
| bus_wdata_i | input | 4 | Bus write data |
| bus_rdata_o | output | 4 | Bus read data, combinational from address |
| ser_data_o | output | 1 | Serial data, 1 when idle or in the acknowledge slot |
| ser_clk_en_o | output | 1 | Sample strobe on the last clock of each slot |
| ser_ack_i | input | 1 | Acknowledge level from the far end |
| ctrl_link_off_o | output | 1 | Stored link-disable control bit |
| ctrl_rack_o | output | 1 | Stored receive-acknowledge control bit |
| irq_o | output | 1 | Serial interrupt pulse |

## Verification
Stored control bits appear one edge after their write. The full flag appears one edge after the second nibble write. A take happens on the next edge, so active and not-full read in the cycle after that. Slot k of a telegram begins k·`SLOT_CYCLES` cycles after the take. The acknowledge status and the end of activity follow one edge after the last clock of slot 8, and the interrupt one further edge later. The bench drives on falling edges and samples just after them. For every one of the 256 byte values it builds a per-cycle expectation from the cycle index since the take, so each result is compared in exactly the cycle it is due.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] ADDR_CTRL = 4'hA;
  localparam logic [NIB_W-1:0] ADDR_TXB  = 4'h9;

  typedef struct packed {
    logic link_off;
    logic rack;
    logic mask;
    logic trig_eot;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{link_off: 1'b1, rack: 1'b1, mask: 1'b1, trig_eot: 1'b1};
endpackage

// File: rtl/nst_regfile.sv
module nst_regfile
  import nst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NIB_W-1:0] addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic             tack_i,
  input  logic             active_i,
  input  logic             full_i,
  output ctrl_t            ctrl_o,
  output logic [NIB_W-1:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  hit_ctrl;

  assign hit_ctrl = (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
    end else if (we_i && hit_ctrl) begin
      ctrl_q <= ctrl_t'(wdata_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o = {1'b0, tack_i, active_i, full_i};
    end
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_ctrl) |=> (ctrl_o == ctrl_t'($past(wdata_i))));
endmodule

// File: rtl/nst_txbuf.sv
module nst_txbuf
  import nst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NIB_W-1:0]  addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o
);
  logic [NIB_W-1:0] half_q [2];
  logic             hi_ptr_q;
  logic             full_q;
  logic             wr_hit;
  logic             completes;

  assign wr_hit    = we_i && (addr_i == ADDR_TXB);
  assign completes = wr_hit && hi_ptr_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        half_q[h] <= '0;
      end else if (wr_hit && (hi_ptr_q == 1'(h))) begin
        half_q[h] <= wdata_i;
      end
    end
    assign data_o[h*NIB_W +: NIB_W] = half_q[h];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_ptr_q <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      if (wr_hit) hi_ptr_q <= ~hi_ptr_q;
      if (completes)   full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign full_o = full_q;

  p_full_after_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    completes |=> full_o);
  p_take_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !completes) |=> !full_o);
  p_low_first_keeps_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && !completes) |=> !full_o);
endmodule

// File: rtl/nst_shifter.sv
module nst_shifter
  import nst_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic              active_o,
  output logic              sdo_o,
  output logic              strobe_o,
  output logic              tack_o,
  output logic              eot_o
);
  localparam int unsigned DIV_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int unsigned SLOT_W = $clog2(BYTE_W + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic              act_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DIV_W-1:0]  div_q;
  logic              tack_q;
  logic              eot_q;
  logic              strobe;
  logic              last_slot;

  assign take_o    = full_i && !act_q;
  assign strobe    = act_q && (div_q == DIV_LAST);
  assign last_slot = (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      act_q  <= 1'b0;
      slot_q <= '0;
      div_q  <= '0;
      tack_q <= 1'b1;
      eot_q  <= 1'b0;
    end else begin
      eot_q <= 1'b0;
      if (take_o) begin
        act_q  <= 1'b1;
        slot_q <= '0;
        div_q  <= '0;
        sh_q   <= data_i;
      end else if (act_q) begin
        if (strobe) begin
          div_q <= '0;
          if (last_slot) begin
            act_q  <= 1'b0;
            tack_q <= ack_i;
            eot_q  <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
            sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign active_o = act_q;
  assign sdo_o    = (act_q && !last_slot) ? sh_q[BYTE_W-1] : 1'b1;
  assign strobe_o = strobe;
  assign tack_o   = tack_q;
  assign eot_o    = eot_q;

  p_strobe_only_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> active_o);
  p_idle_line_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> sdo_o);
  p_take_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> active_o);
  p_ack_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && last_slot) |=> (tack_o == $past(ack_i)) && !active_o && eot_o);
endmodule

// File: rtl/nst_irq.sv
module nst_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic eot_i,
  input  logic mask_i,
  input  logic trig_eot_i,
  output logic irq_o
);
  logic full_prev_q;
  logic irq_q;
  logic full_fell;
  logic event_sel;

  assign full_fell = full_prev_q && !full_i;
  assign event_sel = trig_eot_i ? eot_i : full_fell;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      full_prev_q <= full_i;
      irq_q       <= event_sel && !mask_i;
    end
  end

  assign irq_o = irq_q;

  p_mask_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !irq_o);
  p_eot_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_i && trig_eot_i && !mask_i) |=> irq_o);
endmodule

// File: rtl/nib_ser_tx.sv
module nib_ser_tx
  import nst_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic [3:0] bus_addr_i,
  input  logic [3:0] bus_wdata_i,
  output logic [3:0] bus_rdata_o,
  output logic       ser_data_o,
  output logic       ser_clk_en_o,
  input  logic       ser_ack_i,
  output logic       ctrl_link_off_o,
  output logic       ctrl_rack_o,
  output logic       irq_o
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] buf_data;
  logic              buf_full;
  logic              take;
  logic              active;
  logic              tack;
  logic              eot;

  nst_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .tack_i   (tack),
    .active_i (active),
    .full_i   (buf_full),
    .ctrl_o   (ctrl),
    .rdata_o  (bus_rdata_o)
  );

  nst_txbuf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .take_i  (take),
    .data_o  (buf_data),
    .full_o  (buf_full)
  );

  nst_shifter #(.SLOT_CYCLES(SLOT_CYCLES)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .full_i   (buf_full),
    .data_i   (buf_data),
    .ack_i    (ser_ack_i),
    .take_o   (take),
    .active_o (active),
    .sdo_o    (ser_data_o),
    .strobe_o (ser_clk_en_o),
    .tack_o   (tack),
    .eot_o    (eot)
  );

  nst_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_i     (buf_full),
    .eot_i      (eot),
    .mask_i     (ctrl.mask),
    .trig_eot_i (ctrl.trig_eot),
    .irq_o      (irq_o)
  );

  assign ctrl_link_off_o = ctrl.link_off;
  assign ctrl_rack_o     = ctrl.rack;

  p_take_needs_full_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full && !active) |=> active);
  p_held_while_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full && active) |=> buf_full);
endmodule

// File: tb/nib_ser_tx_tb_top.sv
module nib_ser_tx_tb_top;
  localparam int SC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'hA;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata;
  logic       sdo, sclk_en, ack = 1'b1, link_off, rack, irq;

  int n_checks = 0;
  int n_fail = 0;
  logic tack_exp = 1'b1;

  always #2 clk = ~clk;

  nib_ser_tx #(.SLOT_CYCLES(SC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ser_data_o(sdo),
    .ser_clk_en_o(sclk_en), .ser_ack_i(ack), .ctrl_link_off_o(link_off),
    .ctrl_rack_o(rack), .irq_o(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 4'hA; #1;
  endtask

  // Starts at the first cycle after the take (index 0), addr held at 0xA.
  task automatic check_frame(input logic [7:0] b, input logic ackv, input logic mask,
                             input logic trig, input logic old_tack);
    for (int k = 0; k <= 9*SC + 2; k++) begin
      logic act_e, sdo_e, clk_e, tack_e, irq_e;
      act_e  = (k < 9*SC);
      sdo_e  = (k < 8*SC) ? b[7 - k/SC] : 1'b1;
      clk_e  = act_e && ((k % SC) == SC-1);
      tack_e = act_e ? old_tack : ackv;
      irq_e  = !mask && ((!trig && k == 1) || (trig && k == 9*SC + 1));
      chk(sdo == sdo_e, "R6 serial data", {7'b0, sdo}, {7'b0, sdo_e});
      chk(sclk_en == clk_e, "R6 slot strobe", {7'b0, sclk_en}, {7'b0, clk_e});
      chk(rdata == {1'b0, tack_e, act_e, 1'b0}, "R3 R5 R7 status", {4'b0, rdata},
          {4'b0, 1'b0, tack_e, act_e, 1'b0});
      chk(irq == irq_e, "R8 interrupt", {7'b0, irq}, {7'b0, irq_e});
      @(negedge clk); #1;
    end
  endtask

  task automatic run_frame(input logic [7:0] b);
    logic ackv, mask, trig, lnk, rk;
    ackv = b[0] ^ b[3];
    mask = (b[2:0] == 3'd7);
    trig = b[1];
    lnk  = b[2];
    rk   = b[4];
    ack  = ackv;
    wr(4'hA, {lnk, rk, mask, trig});
    chk(link_off == lnk && rack == rk, "R2 control bits", {6'b0, link_off, rack}, {6'b0, lnk, rk});
    wr(4'h9, b[3:0]);
    chk(rdata[0] == 1'b0, "R4 not full after low half", {7'b0, rdata[0]}, 8'h0);
    wr(4'h9, b[7:4]);
    chk(rdata == {1'b0, tack_exp, 2'b01}, "R4 full after pair", {4'b0, rdata},
        {4'b0, 1'b0, tack_exp, 2'b01});
    @(negedge clk); #1;
    check_frame(b, ackv, mask, trig, tack_exp);
    tack_exp = ackv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(link_off && rack, "R1 control reset", {6'b0, link_off, rack}, 8'h3);
    chk(irq == 1'b0 && sdo == 1'b1, "R1 irq/line reset", {6'b0, irq, sdo}, 8'h1);
    chk(rdata == 4'b0100, "R1 status reset", {4'b0, rdata}, 8'h4);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R3 other addresses read zero
    for (int a = 0; a < 16; a++) begin
      if (a != 10) begin
        addr = 4'(a); #1;
        chk(rdata == 4'h0, "R3 other address", {4'b0, rdata}, 8'h0);
      end
    end
    addr = 4'hA; #1;
    // Sweep all byte values, with mask/trigger/ack drawn from the byte
    for (int b = 0; b < 256; b++) begin
      run_frame(8'(b));
      repeat (2) @(negedge clk);
      #1;
    end
    // R9 and R10: byte queued while busy, with an overwritten pair
    ack = 1'b0;
    wr(4'hA, 4'b0010);
    wr(4'h9, 4'hA);
    wr(4'h9, 4'h5);
    @(negedge clk); #1;
    wr(4'h9, 4'h1);
    wr(4'h9, 4'h2);
    wr(4'h9, 4'h3);
    wr(4'h9, 4'h4);
    chk(rdata[1:0] == 2'b11, "R9 held while active", {6'b0, rdata[1:0]}, 8'h3);
    for (int w = 0; w < 40 && rdata[1]; w++) begin
      @(negedge clk); #1;
    end
    chk(rdata[1:0] == 2'b01, "R9 held at end of telegram", {6'b0, rdata[1:0]}, 8'h1);
    tack_exp = 1'b0;
    @(negedge clk); #1;
    chk(rdata[1:0] == 2'b10, "R9 taken next edge", {6'b0, rdata[1:0]}, 8'h2);
    check_frame(8'h43, 1'b0, 1'b1, 1'b0, 1'b0); // R10 last halves win
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule